// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral is a down-counting supervisor clocked from a slow clock. It starts counting as soon as reset is released. Firmware keeps the system alive by writing a keyed restart command. That restart is honoured only in the late part of the count, when the counter has fallen to or below a programmed window threshold. A restart that comes too early is treated as a fault, just as an underflow is. Either fault can raise an interrupt, and can request a reset of the whole system or of the processor alone.

Configuration lives in a single mode word that accepts exactly one write after reset. That write may shorten the timeout, narrow the window or turn the watchdog off, and it can never be undone until the next reset. Two halt inputs, one for a debugger and one for a low-power idle state, can freeze the count when their enable bits allow it. Software reaches the block through a plain single-cycle register strobe. There is no streaming data path, so no valid/ready handshake exists and the bus never stalls.

Top module: `wdt_windowed`

## Requirements
- R1: After reset the block counts from all ones in the reload width. The mode word reads back with reload and window fields all ones, bit 13 (reset enable) set and every other flag clear. The status word reads zero.
- R2: Each clock that the block is enabled and not halted, the counter drops by one. When the counter is already zero on such a clock, the block raises the underflow flag (status bit 0) and the counter restarts from the reload field (mode bits 11:0).
- R3: A write to offset 0x00 that has 0xA5 in bits 31:24 and bit 0 set is a restart. When the counter is at or below the window field (mode bits 27:16), the restart reloads the counter from the reload field.
- R4: A restart while the counter is above the window field sets the error flag (status bit 1). It does not reload the counter, and the countdown continues.
- R5: A write to offset 0x00 with any other key, or with bit 0 clear, has no effect.
- R6: The mode word at offset 0x04 accepts only its first write after reset, and that write reloads the counter with the new reload value. Every later mode write is ignored.
- R7: With mode bit 15 (off) set, the counter stops, no underflow occurs and restarts are ignored. Because of R6, the watchdog cannot be turned back on.
- R8: A read of offset 0x08 returns {err, unf} in bits 1:0 on the cycle after the read strobe and clears both flags. A fault raised on the same edge as the read wins over the clear. A read of offset 0x04 returns the mode word, and any other offset reads zero.
- R9: irq_o is high exactly while mode bit 12 (interrupt enable) is set and either status flag is set.
- R10: For each fault, when mode bit 13 (reset enable) is set, the block raises a one-cycle reset request on the edge after the fault. The request goes to rst_cpu_o if mode bit 14 (processor only) is set, and to rst_sys_o otherwise. The two outputs are never high together.
- R11: While dbg_halt_i is high and mode bit 28 is set, or while idle_halt_i is high and mode bit 29 is set, the counter holds its value and no underflow occurs. A halt input whose enable bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that drives the counter and the registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one clock per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x00 command, 0x04 mode, 0x08 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe and held until the next read |
| dbg_halt_i | input | 1 | Debugger halt request |
| idle_halt_i | input | 1 | Low-power idle indication |
| irq_o | output | 1 | Fault interrupt, level |
| rst_sys_o | output | 1 | System reset request, one-cycle pulse |
| rst_cpu_o | output | 1 | Processor-only reset request, one-cycle pulse |

## Verification
Every fault is decided on the clock edge where its condition holds, and it becomes visible one edge later. That edge sets the status flag, drives irq_o and produces the reset pulse, and a read strobe returns its data one edge after the strobe. The bench drives inputs on the falling edge and advances an arithmetic model of the counter, flags and mode word once per rising edge. At the next falling edge it compares irq_o, both reset outputs and, after reads, bus_rdata. Because of this, each result is checked in exactly the cycle in which it is due. A small five-bit counter lets the bench sweep a restart attempt at every counter value from reload down to zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WDT_KEY   = 8'hA5;
  localparam int OFS_CMD           = 0;
  localparam int OFS_MODE          = 4;
  localparam int OFS_STAT          = 8;
  localparam int KEY_LSB           = 24;
  localparam int BIT_RESTART       = 0;
  localparam int BIT_IRQ_EN        = 12;
  localparam int BIT_RST_EN        = 13;
  localparam int BIT_CPU_ONLY      = 14;
  localparam int BIT_OFF           = 15;
  localparam int WIN_LSB           = 16;
  localparam int BIT_DBG_HOLD      = 28;
  localparam int BIT_IDLE_HOLD     = 29;

  typedef struct packed {
    logic idle_hold;
    logic dbg_hold;
    logic off;
    logic cpu_only;
    logic rst_en;
    logic irq_en;
  } wdt_ctl_t;

  localparam wdt_ctl_t CTL_RESET = '{idle_hold: 1'b0, dbg_hold: 1'b0, off: 1'b0,
                                     cpu_only: 1'b0, rst_en: 1'b1, irq_en: 1'b0};
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              ev_unf,
  input  logic              ev_err,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  window_q,
  output wdt_ctl_t          ctl_q,
  output logic              mode_load,
  output logic [CNT_W-1:0]  load_val,
  output logic              restart_req,
  output logic              unf_q,
  output logic              err_q,
  output logic [31:0]       bus_rdata
);
  logic locked_q;
  logic wr_cmd, wr_mode, rd_acc, rd_stat, key_ok;
  logic [31:0] mode_img;
  logic [31:0] stat_img;

  always_comb begin
    wr_cmd  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    wr_mode = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_MODE));
    rd_acc  = bus_en && !bus_we;
    rd_stat = rd_acc && (bus_addr == ADDR_W'(OFS_STAT));
    key_ok  = (bus_wdata[KEY_LSB +: 8] == WDT_KEY);
  end

  assign restart_req = wr_cmd && key_ok && bus_wdata[BIT_RESTART] && !ctl_q.off;
  assign mode_load   = wr_mode && !locked_q;
  assign load_val    = bus_wdata[CNT_W-1:0];

  always_comb begin
    mode_img                      = '0;
    mode_img[CNT_W-1:0]           = reload_q;
    mode_img[WIN_LSB +: CNT_W]    = window_q;
    mode_img[BIT_IRQ_EN]          = ctl_q.irq_en;
    mode_img[BIT_RST_EN]          = ctl_q.rst_en;
    mode_img[BIT_CPU_ONLY]        = ctl_q.cpu_only;
    mode_img[BIT_OFF]             = ctl_q.off;
    mode_img[BIT_DBG_HOLD]        = ctl_q.dbg_hold;
    mode_img[BIT_IDLE_HOLD]       = ctl_q.idle_hold;
    stat_img                      = {30'd0, err_q, unf_q};
  end

  // write-once mode word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      window_q <= '1;
      ctl_q    <= CTL_RESET;
      locked_q <= 1'b0;
    end else if (mode_load) begin
      reload_q       <= bus_wdata[CNT_W-1:0];
      window_q       <= bus_wdata[WIN_LSB +: CNT_W];
      ctl_q.irq_en   <= bus_wdata[BIT_IRQ_EN];
      ctl_q.rst_en   <= bus_wdata[BIT_RST_EN];
      ctl_q.cpu_only <= bus_wdata[BIT_CPU_ONLY];
      ctl_q.off      <= bus_wdata[BIT_OFF];
      ctl_q.dbg_hold <= bus_wdata[BIT_DBG_HOLD];
      ctl_q.idle_hold<= bus_wdata[BIT_IDLE_HOLD];
      locked_q       <= 1'b1;
    end
  end

  // sticky status, cleared by a status read, a new fault wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unf_q <= ev_unf || (unf_q && !rd_stat);
      err_q <= ev_err || (err_q && !rd_stat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      if (bus_addr == ADDR_W'(OFS_MODE))      bus_rdata <= mode_img;
      else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata <= stat_img;
      else                                    bus_rdata <= '0;
    end
  end

  // R6: once locked the configuration never moves
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> ($stable(reload_q) && $stable(window_q) && $stable(ctl_q)));

  // R8: a status read with no new fault leaves both flags clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ev_unf && !ev_err) |=> (!unf_q && !err_q));

  // R7: a turned-off watchdog never asks for a restart
  a_r7_no_restart_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.off |-> !restart_req);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] window,
  input  logic             off,
  input  logic             halt,
  input  logic             mode_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             restart_req,
  output logic             ev_unf,
  output logic             ev_err
);
  logic [CNT_W-1:0] cnt_q;
  logic in_window, restart_ok, tick, at_zero;

  always_comb begin
    in_window  = (cnt_q <= window);
    restart_ok = restart_req && in_window;
    tick       = !off && !halt;
    at_zero    = (cnt_q == '0);
    ev_err     = restart_req && !in_window;
    ev_unf     = !mode_load && !restart_ok && tick && at_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '1;
    else if (mode_load)  cnt_q <= load_val;
    else if (restart_ok) cnt_q <= reload;
    else if (tick)       cnt_q <= at_zero ? reload : cnt_q - 1'b1;
  end

  // R11: a halted counter holds
  a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !mode_load && !restart_req) |=> $stable(cnt_q));

  // R7: a turned-off counter holds
  a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !mode_load) |=> $stable(cnt_q));

  // R2: underflow restarts the count from the reload field
  a_r2_unf_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> (cnt_q == $past(reload)));

  // R3: an accepted restart reloads
  a_r3_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && (cnt_q <= window)) |=> (cnt_q == $past(reload)));

  // R4: a restart and an underflow never share an edge with a reload of the other kind
  a_r4_err_no_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> (cnt_q != '0));
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdt_ctl_t ctl,
  input  logic     ev_unf,
  input  logic     ev_err,
  input  logic     unf_q,
  input  logic     err_q,
  output logic     irq_o,
  output logic     rst_sys_o,
  output logic     rst_cpu_o
);
  localparam int N_ROUTE = 2;   // 0: system, 1: processor only

  logic       fault;
  logic [N_ROUTE-1:0] pulse_q;

  assign fault = ev_unf || ev_err;
  assign irq_o = ctl.irq_en && (unf_q || err_q);

  for (genvar g = 0; g < N_ROUTE; g++) begin : g_route
    logic pick;
    assign pick = (g == 1) ? ctl.cpu_only : !ctl.cpu_only;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[g] <= 1'b0;
      else        pulse_q[g] <= fault && ctl.rst_en && pick;
    end
  end

  assign rst_sys_o = pulse_q[0];
  assign rst_cpu_o = pulse_q[1];

  // R10: never both requests together
  a_r10_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_sys_o, rst_cpu_o}));

  // R10: a request follows a fault by one edge
  a_r10_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault && ctl.rst_en |=> (rst_sys_o || rst_cpu_o));
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt_i,
  input  logic              idle_halt_i,
  output logic              irq_o,
  output logic              rst_sys_o,
  output logic              rst_cpu_o
);
  logic [CNT_W-1:0] reload, window, load_val;
  wdt_ctl_t         ctl;
  logic             mode_load, restart_req, unf_q, err_q, ev_unf, ev_err, halt;
  logic [1:0]       hold_src, hold_en;

  assign hold_src = {idle_halt_i, dbg_halt_i};
  assign hold_en  = {ctl.idle_hold, ctl.dbg_hold};
  assign halt     = |(hold_src & hold_en);

  wdt_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ev_unf(ev_unf), .ev_err(ev_err),
    .reload_q(reload), .window_q(window), .ctl_q(ctl),
    .mode_load(mode_load), .load_val(load_val), .restart_req(restart_req),
    .unf_q(unf_q), .err_q(err_q), .bus_rdata(bus_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .reload(reload), .window(window), .off(ctl.off), .halt(halt),
    .mode_load(mode_load), .load_val(load_val), .restart_req(restart_req),
    .ev_unf(ev_unf), .ev_err(ev_err)
  );

  wdt_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .ev_unf(ev_unf), .ev_err(ev_err), .unf_q(unf_q), .err_q(err_q),
    .irq_o(irq_o), .rst_sys_o(rst_sys_o), .rst_cpu_o(rst_cpu_o)
  );

  // R9: the interrupt never rises without an enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ctl.irq_en);
endmodule

// File: tb/sim_wdt_windowed.sv
module sim_wdt_windowed;
  localparam int CW = 5;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, we = 1'b0, dbg = 1'b0, idl = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rsys, rcpu;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_windowed #(.CNT_W(CW), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .dbg_halt_i(dbg), .idle_halt_i(idl),
    .irq_o(irq), .rst_sys_o(rsys), .rst_cpu_o(rcpu)
  );

  // reference state
  int m_cnt, m_rel, m_win;
  bit m_irqen, m_rsten, m_cpu, m_off, m_dbgh, m_idleh, m_lock, m_unf, m_err, m_rs, m_rc;
  logic [31:0] m_rdata;

  function automatic logic [31:0] mk(int rel, int win, bit ie, bit re, bit cpu, bit off, bit dh, bit ih);
    logic [31:0] w;
    w = 32'(rel) | (32'(win) << 16);
    w[12] = ie; w[13] = re; w[14] = cpu; w[15] = off; w[28] = dh; w[29] = ih;
    return w;
  endfunction

  task automatic m_reset();
    m_cnt = FULL; m_rel = FULL; m_win = FULL;
    m_irqen = 0; m_rsten = 1; m_cpu = 0; m_off = 0; m_dbgh = 0; m_idleh = 0;
    m_lock = 0; m_unf = 0; m_err = 0; m_rs = 0; m_rc = 0;
  endtask

  task automatic m_update();
    bit wrm, rq, hl, eu, ee, srd;
    int nc;
    if (!rst_n) begin m_reset(); m_rdata = '0; return; end
    wrm = en && we && addr == 4'd4 && !m_lock;
    rq  = en && we && addr == 4'd0 && wdata[31:24] == 8'hA5 && wdata[0] && !m_off;
    hl  = (dbg && m_dbgh) || (idl && m_idleh);
    eu = 0; ee = rq && (m_cnt > m_win); nc = m_cnt;
    if (wrm) nc = int'(wdata[CW-1:0]);
    else if (rq && m_cnt <= m_win) nc = m_rel;
    else if (!m_off && !hl) begin
      if (m_cnt == 0) begin eu = 1; nc = m_rel; end else nc = m_cnt - 1;
    end
    if (en && !we) begin
      if (addr == 4'd4) m_rdata = mk(m_rel, m_win, m_irqen, m_rsten, m_cpu, m_off, m_dbgh, m_idleh);
      else if (addr == 4'd8) m_rdata = {30'd0, m_err, m_unf};
      else m_rdata = '0;
    end
    srd = en && !we && addr == 4'd8;
    m_unf = eu || (m_unf && !srd);
    m_err = ee || (m_err && !srd);
    m_rs = (eu || ee) && m_rsten && !m_cpu;
    m_rc = (eu || ee) && m_rsten && m_cpu;
    if (wrm) begin
      m_rel = int'(wdata[CW-1:0]); m_win = int'(wdata[16 +: CW]);
      m_irqen = wdata[12]; m_rsten = wdata[13]; m_cpu = wdata[14]; m_off = wdata[15];
      m_dbgh = wdata[28]; m_idleh = wdata[29]; m_lock = 1;
    end
    m_cnt = nc;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_update();
    @(negedge clk);
    check(32'(irq), 32'(m_irqen && (m_unf || m_err)), "R9 irq level");
    check({30'd0, rcpu, rsys}, {30'd0, m_rc, m_rs}, "R10 reset request");
  endtask

  task automatic idle_n(input int n);
    en = 0; we = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    en = 1; we = 1; addr = a; wdata = d;
    step();
    en = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    en = 1; we = 0; addr = a;
    step();
    en = 0;
    check(rdata, m_rdata, tag);
  endtask

  task automatic do_reset();
    rst_n = 0; en = 0; we = 0; dbg = 0; idl = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic sync_restart();
    while (m_cnt > m_win) idle_n(1);
    wr(4'd0, 32'hA500_0001);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(4'd4, "R1 mode reset value");
    check(m_rdata, 32'h001F_201F, "R1 mode reset constant");
    rd(4'd8, "R1 status reset");
    // R3 full window: every restart accepted
    for (int k = 0; k < 6; k++) begin idle_n(k * 3); wr(4'd0, 32'hA500_0001); end
    rd(4'd8, "R3 no error with wide window");
    // R2 underflow to a system reset
    idle_n(FULL + 3);
    rd(4'd8, "R2 R8 underflow flag");
    rd(4'd8, "R8 cleared by read");
    // R5 bad key / missing bit
    wr(4'd0, 32'h5A00_0001); wr(4'd0, 32'hA500_0000);
    idle_n(2);
    rd(4'd8, "R5 ignored command");

    // R6 single configuration
    wr(4'd4, mk(20, 8, 1, 1, 0, 0, 1, 0));
    rd(4'd4, "R6 mode written");
    wr(4'd4, mk(3, 1, 0, 0, 1, 1, 0, 1));
    rd(4'd4, "R6 second write ignored");
    // R3 R4 sweep of restart position
    for (int off = 0; off <= 22; off++) begin
      sync_restart();
      idle_n(off);
      wr(4'd0, 32'hA500_0001);
      rd(4'd8, "R3 R4 window sweep");
    end
    // R5 wrong key while outside window
    sync_restart();
    wr(4'd0, 32'hA600_0001);
    rd(4'd8, "R5 no error on bad key");
    // R11 halts
    sync_restart();
    dbg = 1; idle_n(30); dbg = 0;
    rd(4'd8, "R11 debug halt holds");
    idl = 1; idle_n(25); idl = 0;
    rd(4'd8, "R11 idle halt not enabled");
    idle_n(20);
    rd(4'd8, "R2 underflow after halt");
    // R8 fault on same edge as read
    sync_restart();
    while (m_cnt != 0) idle_n(1);
    rd(4'd8, "R8 fault wins over clear");
    rd(4'd8, "R8 flag seen");

    // R10 processor-only route
    do_reset();
    wr(4'd4, mk(6, 3, 0, 1, 1, 0, 0, 0));
    idle_n(16);
    wr(4'd0, 32'hA500_0001);
    rd(4'd8, "R10 R4 early restart");
    idle_n(10);

    // R7 turned off
    do_reset();
    wr(4'd4, mk(4, 2, 1, 1, 0, 1, 0, 0));
    idle_n(40);
    wr(4'd0, 32'hA500_0001);
    rd(4'd8, "R7 nothing while off");
    wr(4'd4, mk(4, 2, 1, 1, 0, 0, 0, 0));
    idle_n(40);
    rd(4'd4, "R7 cannot re-enable");
    rd(4'd8, "R7 still quiet");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule